// File: doc/BRIEF.md
# Timer Compare PWM Capture Channel

A single timer channel built around a free-running up-counter and one general register. A two-bit mode field selects one of four behaviours. In compare mode a counter match sets, clears or toggles the timer output. In PWM mode the output follows a less-or-equal comparison between the counter and the general register, with a selectable polarity. In capture mode a qualified edge on the timer input copies the counter into the general register. The fourth mode is idle.

Software reaches the channel through a small word-wide register port. Writes take effect at the clock edge on which `we_i` is high. Reads are combinational from `addr_i`. The meaning of the two live bits of the 8-bit level register depends on the mode. It picks the output action in compare and PWM modes and the edge trigger in capture mode.

Register map: address 0 is control, with bit 0 as the run enable and bits 2:1 as the mode (00 compare, 01 PWM, 10 capture, 11 idle). Address 1 is the level register. Address 2 is the general register. Address 3 is status: bit 0 is the capture flag, and writing 1 to bit 0 clears it. Address 4 is the counter, read-only. Any other address reads as zero.

Top module: `tmr_chan`

## Requirements
- R1: After reset the output is low, the capture flag is clear, and control, level, general register and counter all read 0.
- R2: The level register is 8 bits wide, but only bits 1:0 are stored; bits 7:2 always read as 0.
- R3: While run is 1 the counter adds one on every clock and wraps from 0xFFFF to 0; while run is 0 it holds its value.
- R4: In compare mode a match is a running counter equal to the general register. It is judged on the counter value before the increment, and the output changes at that same clock edge. Level 00 drives the output low on a match and level 01 drives it high.
- R5: In compare mode level 10 inverts the output once per match and level 11 leaves the output unchanged.
- R6: In PWM mode the output is registered from the comparison counter <= general register. Level 00 gives low when it holds and high otherwise; level 01 gives the inverse.
- R7: In PWM mode any level with bit 1 set drives the output low.
- R8: In capture mode, level 01 captures on rising input edges, 10 on falling edges and 11 on both. The input passes through two synchroniser flops and one history flop, so the capture happens at the third rising clock edge after the input changes.
- R9: In capture mode level 00 ignores input edges. Idle mode (11) captures nothing. In capture and idle modes the output holds its value.
- R10: A capture sets the sticky capture flag. Writing 1 to status bit 0 clears it and writing 0 leaves it set. A capture in the same cycle as a clear wins.
- R11: A capture loads the general register with the counter value present at the capture edge, and it takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data |
| tin_i | input | 1 | Timer input, asynchronous |
| tout_o | output | 1 | Timer output |
| cap_flag_o | output | 1 | Sticky capture event flag |

## Verification
The bench targets the compare boundary: the output must stay put while the counter equals the general register and change on the very next edge. It also checks that a toggle acts only once per match, which a design comparing after the increment, or on every cycle in a match window, would break. In PWM mode it freezes the counter and moves the general register across the counter value, so an off-by-one `<` would flip the equal case. In capture mode it checks the three-edge latency, that the wrong edge is rejected, that level 00 and idle mode ignore edges, and that a captured running count equals the count read just before the capture edge. A design with a missing history flop or inverted edge selection shows up there.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_CMP  = 2'b00,
    MODE_PWM  = 2'b01,
    MODE_CAP  = 2'b10,
    MODE_IDLE = 2'b11
  } tmr_mode_e;

  localparam int unsigned LVL_REG_W = 8;
  localparam int unsigned LVL_W     = 2;
  localparam int unsigned ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LVL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_GREG = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;  // natural wrap
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tin_i,
  input  logic                      en_i,
  input  logic [tmr_pkg::LVL_W-1:0] sel_i,
  output logic                      evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              sync_v;
  logic              rise, fall;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tin_i};
      end
    end
  endgenerate

  assign sync_v = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= sync_v;
  end

  assign rise  = sync_v & ~hist_q;
  assign fall  = ~sync_v & hist_q;
  // sel bit 0 arms rising, bit 1 arms falling
  assign evt_o = en_i & ((sel_i[0] & rise) | (sel_i[1] & fall));
endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  tmr_pkg::tmr_mode_e        mode_i,
  input  logic [tmr_pkg::LVL_W-1:0] lvl_i,
  input  logic                      run_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [CNT_W-1:0]          greg_i,
  output logic                      out_o
);
  import tmr_pkg::*;

  logic out_q, out_d;
  logic match, at_or_below;

  assign match       = run_i && (cnt_i == greg_i);  // pre-increment value
  assign at_or_below = (cnt_i <= greg_i);

  always_comb begin
    out_d = out_q;
    case (mode_i)
      MODE_CMP: begin
        if (match) begin
          case (lvl_i)
            2'b00:   out_d = 1'b0;
            2'b01:   out_d = 1'b1;
            2'b10:   out_d = ~out_q;
            default: out_d = out_q;
          endcase
        end
      end
      MODE_PWM: begin
        if (lvl_i[1]) out_d = 1'b0;
        else          out_d = at_or_below ? lvl_i[0] : ~lvl_i[0];
      end
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [CNT_W-1:0]           rdata_o,
  input  logic                       cap_evt_i,
  input  logic [CNT_W-1:0]           cnt_i,
  output logic                       run_o,
  output tmr_pkg::tmr_mode_e         mode_o,
  output logic [tmr_pkg::LVL_W-1:0]  lvl_o,
  output logic [CNT_W-1:0]           greg_o,
  output logic                       flag_o
);
  import tmr_pkg::*;

  logic             run_q;
  tmr_mode_e        mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] greg_q;
  logic             flag_q;

  logic wr_ctrl, wr_lvl, wr_greg, wr_stat;
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_lvl  = we_i && (addr_i == A_LVL);
  assign wr_greg = we_i && (addr_i == A_GREG);
  assign wr_stat = we_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_CMP;
    end else if (wr_ctrl) begin
      run_q  <= wdata_i[0];
      mode_q <= tmr_mode_e'(wdata_i[2:1]);
    end
  end

  // reserved level bits are dropped on write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (wr_lvl) lvl_q <= wdata_i[LVL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        greg_q <= '0;
    else if (cap_evt_i) greg_q <= cnt_i;
    else if (wr_greg)   greg_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (cap_evt_i)              flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0])  flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[0]   = run_q;
        rdata_o[2:1] = mode_q;
      end
      A_LVL:  rdata_o[LVL_W-1:0] = lvl_q;
      A_GREG: rdata_o = greg_q;
      A_STAT: rdata_o[0] = flag_q;
      A_CNT:  rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign lvl_o  = lvl_q;
  assign greg_o = greg_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [CNT_W-1:0]           rdata_o,
  input  logic                       tin_i,
  output logic                       tout_o,
  output logic                       cap_flag_o
);
  import tmr_pkg::*;

  logic             run;
  tmr_mode_e        mode;
  logic [LVL_W-1:0] lvl;
  logic [CNT_W-1:0] greg;
  logic [CNT_W-1:0] cnt;
  logic             cap_evt;
  logic             cap_en;

  assign cap_en = (mode == MODE_CAP);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .cnt_o (cnt)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tin_i (tin_i),
    .en_i  (cap_en),
    .sel_i (lvl),
    .evt_o (cap_evt)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cap_evt_i(cap_evt),
    .cnt_i    (cnt),
    .run_o    (run),
    .mode_o   (mode),
    .lvl_o    (lvl),
    .greg_o   (greg),
    .flag_o   (cap_flag_o)
  );

  tmr_out_gen #(.CNT_W(CNT_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .lvl_i (lvl),
    .run_i (run),
    .cnt_i (cnt),
    .greg_i(greg),
    .out_o (tout_o)
  );
endmodule

// File: rtl/tmr_chan_sva.sv
module tmr_chan_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       run_i,
  input tmr_pkg::tmr_mode_e         mode_i,
  input logic [tmr_pkg::LVL_W-1:0]  lvl_i,
  input logic [CNT_W-1:0]           cnt_i,
  input logic [CNT_W-1:0]           greg_i,
  input logic                       cap_evt_i,
  input logic                       tout_i,
  input logic                       flag_i,
  input logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]           rdata_i
);
  import tmr_pkg::*;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  assert_lvl_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_LVL) |-> (rdata_i[CNT_W-1:LVL_W] == '0));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMP && lvl_i == 2'b10 && run_i && cnt_i == greg_i)
      |=> tout_i != $past(tout_i));

  assert_pwm_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PWM && lvl_i[1]) |=> !tout_i);

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CAP || mode_i == MODE_IDLE) |=> $stable(tout_i));

  assert_cap_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |-> (mode_i == MODE_CAP && lvl_i != 2'b00));

  assert_flag_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(cap_evt_i));

  assert_cap_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> greg_i == $past(cnt_i));
endmodule

bind tmr_chan tmr_chan_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run),
  .mode_i   (mode),
  .lvl_i    (lvl),
  .cnt_i    (cnt),
  .greg_i   (greg),
  .cap_evt_i(cap_evt),
  .tout_i   (tout_o),
  .flag_i   (cap_flag_o),
  .addr_i   (addr_i),
  .rdata_i  (rdata_o)
);

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  // default unit 1 ps; 4 ns period
  localparam int CNT_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [2:0]        addr_i = 3'd0;
  logic [CNT_W-1:0]  wdata_i = '0;
  logic [CNT_W-1:0]  rdata_o;
  logic              tin_i = 1'b0;
  logic              tout_o;
  logic              cap_flag_o;

  tmr_chan #(.CNT_W(CNT_W)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .tin_i     (tin_i),
    .tout_o    (tout_o),
    .cap_flag_o(cap_flag_o)
  );

  always #2000 clk_i = ~clk_i;

  localparam logic [2:0] CTRL = 3'd0, LVL = 3'd1, GREG = 3'd2, STAT = 3'd3, CNT = 3'd4;
  localparam int K_OUT = 0, K_FLAG = 1, K_RD = 2;

  typedef struct {
    int              kind;
    logic [CNT_W-1:0] exp;
    string           req;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     chk_ev;
  int       n_vec = 0;
  int       n_bad = 0;
  bit       done  = 1'b0;

  // monitor: pops expected items and compares against live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [CNT_W-1:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          K_OUT:   got = {{(CNT_W-1){1'b0}}, tout_o};
          K_FLAG:  got = {{(CNT_W-1){1'b0}}, cap_flag_o};
          default: got = rdata_o;
        endcase
        n_vec++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [CNT_W-1:0] exp, input string req);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    ->chk_ev;
    #50;
  endtask

  task automatic exp_out(input logic e, input string req);
    push(K_OUT, {{(CNT_W-1){1'b0}}, e}, req);
  endtask

  task automatic exp_flag(input logic e, input string req);
    push(K_FLAG, {{(CNT_W-1){1'b0}}, e}, req);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [CNT_W-1:0] e, input string req);
    addr_i = a;
    #50;
    push(K_RD, e, req);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // called just after a negedge; write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; we_i = 1'b0; tin_i = 1'b0;
    tick(2);
    rst_ni = 1'b1;
  endtask

  task automatic wait_cnt(input logic [CNT_W-1:0] v);
    int guard;
    guard = 0;
    addr_i = CNT;
    #50;
    while (rdata_o !== v && guard < 70000) begin
      @(negedge clk_i);
      addr_i = CNT;
      #50;
      guard++;
    end
  endtask

  initial begin
    #(200000 * 4000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] snap;
    tick(1);
    do_reset();

    // R1 reset state
    exp_out(1'b0, "R1 out");
    exp_flag(1'b0, "R1 flag");
    exp_rd(CTRL, 16'h0, "R1 ctrl");
    exp_rd(LVL,  16'h0, "R1 level");
    exp_rd(GREG, 16'h0, "R1 greg");
    exp_rd(CNT,  16'h0, "R1 cnt");

    // R2 reserved level bits
    wr(LVL, 16'h00FF);
    exp_rd(LVL, 16'h0003, "R2 level readback");
    wr(LVL, 16'h0000);

    // R3 count / hold
    wr(CTRL, 16'h0001);
    tick(4);
    exp_rd(CNT, 16'd4, "R3 count");
    wr(CTRL, 16'h0000);
    tick(3);
    exp_rd(CNT, 16'd5, "R3 hold");

    // R3 wrap
    do_reset();
    wr(CTRL, 16'h0001);
    wait_cnt(16'hFFFF);
    exp_rd(CNT, 16'hFFFF, "R3 top");
    tick(1);
    exp_rd(CNT, 16'h0000, "R3 wrap");

    // R4 compare set then clear
    do_reset();
    wr(GREG, 16'd5);
    wr(LVL, 16'd1);
    wr(CTRL, 16'h0001);
    wait_cnt(16'd5);
    exp_out(1'b0, "R4 before match");
    tick(1);
    exp_out(1'b1, "R4 set on match");
    wr(LVL, 16'd0);
    wr(GREG, 16'd12);
    wait_cnt(16'd12);
    exp_out(1'b1, "R4 before clear");
    tick(1);
    exp_out(1'b0, "R4 clear on match");

    // R5 toggle once per match, level 11 holds
    wr(LVL, 16'd2);
    wr(GREG, 16'd20);
    wait_cnt(16'd20);
    exp_out(1'b0, "R5 before toggle");
    tick(1);
    exp_out(1'b1, "R5 toggle");
    tick(1);
    exp_out(1'b1, "R5 toggle once");
    wr(GREG, 16'd25);
    wait_cnt(16'd25);
    tick(1);
    exp_out(1'b0, "R5 toggle back");
    wr(LVL, 16'd1);
    wr(GREG, 16'd30);
    wait_cnt(16'd30);
    tick(1);
    exp_out(1'b1, "R5 setup high");
    wr(LVL, 16'd0);
    wr(LVL, 16'd3);
    wr(GREG, 16'd35);
    wait_cnt(16'd35);
    tick(1);
    exp_out(1'b1, "R5 level 11 holds");

    // R6/R7 PWM with frozen counter at 11
    do_reset();
    wr(CTRL, 16'h0001);
    wait_cnt(16'd10);
    wr(CTRL, 16'h0002);
    exp_rd(CNT, 16'd11, "R3 frozen");
    wr(GREG, 16'd11);
    tick(1);
    exp_out(1'b0, "R6 equal gives low");
    wr(GREG, 16'd10);
    tick(1);
    exp_out(1'b1, "R6 above gives high");
    wr(LVL, 16'd1);
    tick(1);
    exp_out(1'b0, "R6 inverse above");
    wr(GREG, 16'd11);
    tick(1);
    exp_out(1'b1, "R6 inverse equal");
    wr(LVL, 16'd2);
    tick(1);
    exp_out(1'b0, "R7 level 10 low");
    wr(LVL, 16'd0);
    wr(GREG, 16'd10);
    tick(1);
    exp_out(1'b1, "R6 setup high");
    wr(LVL, 16'd3);
    tick(1);
    exp_out(1'b0, "R7 level 11 low");

    // R9 idle holds output
    wr(LVL, 16'd0);
    tick(1);
    wr(CTRL, 16'h0006);
    wr(GREG, 16'd11);
    tick(2);
    exp_out(1'b1, "R9 idle holds");

    // R8/R10/R11 capture with frozen counter at 41
    do_reset();
    wr(CTRL, 16'h0001);
    wait_cnt(16'd40);
    wr(CTRL, 16'h0004);
    wr(LVL, 16'd1);
    tin_i = 1'b1;
    tick(2);
    exp_flag(1'b0, "R8 latency not early");
    tick(1);
    exp_flag(1'b1, "R8 rising capture");
    exp_rd(GREG, 16'd41, "R11 captured value");
    exp_rd(STAT, 16'd1, "R10 status bit");
    wr(STAT, 16'd0);
    exp_flag(1'b1, "R10 write 0 keeps");
    wr(STAT, 16'd1);
    exp_flag(1'b0, "R10 write 1 clears");

    wr(GREG, 16'hAAAA);
    tin_i = 1'b0;
    tick(4);
    exp_flag(1'b0, "R8 falling ignored on 01");
    exp_rd(GREG, 16'hAAAA, "R8 greg kept");

    wr(LVL, 16'd2);
    tin_i = 1'b1;
    tick(4);
    exp_flag(1'b0, "R8 rising ignored on 10");
    tin_i = 1'b0;
    tick(3);
    exp_flag(1'b1, "R8 falling capture");
    exp_rd(GREG, 16'd41, "R8 falling value");
    wr(STAT, 16'd1);

    wr(LVL, 16'd3);
    wr(GREG, 16'd0);
    tin_i = 1'b1;
    tick(3);
    exp_flag(1'b1, "R8 both rising");
    exp_rd(GREG, 16'd41, "R8 both rising value");
    wr(STAT, 16'd1);
    wr(GREG, 16'd0);
    tin_i = 1'b0;
    tick(3);
    exp_flag(1'b1, "R8 both falling");
    exp_rd(GREG, 16'd41, "R8 both falling value");

    wr(STAT, 16'd1);
    wr(LVL, 16'd0);
    wr(GREG, 16'h1234);
    tin_i = 1'b1;
    tick(4);
    tin_i = 1'b0;
    tick(4);
    exp_flag(1'b0, "R9 level 00 ignores");
    exp_rd(GREG, 16'h1234, "R9 greg untouched");

    wr(CTRL, 16'h0006);
    wr(LVL, 16'd3);
    tin_i = 1'b1;
    tick(4);
    exp_flag(1'b0, "R9 idle no capture");
    exp_rd(GREG, 16'h1234, "R9 idle greg");

    // R11 capture of a running count
    wr(CTRL, 16'h0005);
    wr(LVL, 16'd1);
    tin_i = 1'b0;
    tick(4);
    exp_flag(1'b0, "R8 falling ignored running");
    tin_i = 1'b1;
    tick(2);
    addr_i = CNT;
    #50;
    snap = rdata_o;
    tick(1);
    exp_rd(GREG, snap, "R11 running capture");
    exp_flag(1'b1, "R10 running flag");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule